// File: doc/BRIEF.md
# Bridge Posted-Write Ordering Controller

This block decides what happens to every transaction that reaches either side of a two-sided PCI-style bridge and is meant to cross it. Each request is classified from its 4-bit command code and gets one of three registered outcomes, one cycle after the request strobe. It may be taken as a posted write, so the initiator is released at once and the data goes into the posting buffer. It may be accepted for forwarding as a non-posted transaction. Or it may be terminated with retry. Commands the bridge never claims get no outcome at all.

Ordering is enforced against the posting buffer that holds writes which entered on the *other* side. While that buffer still holds data, any non-postable access is retried, because a read or configuration access must not overtake earlier posted writes. A flush request per buffer is raised toward the far-side arbitration logic for as long as the buffer reports non-empty.

Write posting can be switched off at run time through a control bit in configuration space. The bit has an effect only while a hardware strap grants software control. With posting off, a memory write is treated like any non-posted transaction. This gives a fallback for systems whose host side cannot drain posted writes while it repeats a retried access.

Top module: `bridge_post_order`

## Requirements
- R1: While reset is high and in the cycle after reset, all decision outputs and flush requests are 0. The posting-disable bit resets to 0, so posting is enabled after reset even with the strap high.
- R2: With posting enabled, a request carrying Memory Write (4'h7) or Memory Write and Invalidate (4'hF) yields `dec_post` for that side in the cycle after the strobe, whatever the buffers hold.
- R3: A request carrying a non-postable command yields `dec_accept` in the cycle after the strobe when the opposite side's posting buffer is empty. The non-postable commands are I/O Read 4'h2, I/O Write 4'h3, Memory Read 4'h6, Configuration Read 4'hA, Configuration Write 4'hB, Memory Read Multiple 4'hC and Memory Read Line 4'hE.
- R4: A non-postable request yields `dec_retry` while the opposite side's posting buffer is non-empty. The retry repeats on every attempt until that buffer reports empty, and then the same access is accepted.
- R5: Interrupt Acknowledge (4'h0), Special Cycle (4'h1) and every other unlisted code (4'h4, 4'h5, 4'h8, 4'h9, 4'hD) produce no decision output.
- R6: A configuration write sets the posting-disable bit from data bit 1 only when the dword address is 40h (address bits 7:2 equal 6'h10) and byte enable 0 is set. Any other configuration write leaves the bit unchanged.
- R7: While `strap_sw_ctl` is 0, memory writes are posted regardless of the posting-disable bit.
- R8: With the strap at 1 and the disable bit at 1, a memory write is handled like a non-postable command. It is accepted when the opposite buffer is empty and retried otherwise.
- R9: `flush_req[s]` is 1 in the cycle after `pbuf_empty[s]` is sampled 0, and 0 in the cycle after it is sampled 1.
- R10: A side's own posting buffer does not block that side's non-postable requests.
- R11: At most one decision output per side is active in any cycle. None is active in the cycle after a cycle without a request strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 2 | Request strobe per side (0 primary, 1 secondary) |
| in_cmd | input | 2x4 | Command code per side |
| pbuf_empty | input | 2 | Posting buffer of writes entered at side s is empty |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Configuration byte enables |
| strap_sw_ctl | input | 1 | Strap: 1 lets software disable posting |
| dec_accept | output | 2 | Accept for non-posted forwarding, per side |
| dec_post | output | 2 | Complete as posted write, per side |
| dec_retry | output | 2 | Terminate with retry, per side |
| flush_req | output | 2 | Flush request for the buffer of side s |

## Verification
The bench builds the block with its default parameters: a 32-bit configuration dword, the control register at offset 40h and the disable flag at bit 1. With these values the byte-lane gate, the dword decode and the strap gating can all be reached with a handful of configuration writes. A scoreboard predicts every cycle's outputs for both sides together, covering the flush requests. The stimulus sweeps all sixteen command codes on each side, against an empty and a non-empty opposite buffer. It then walks through a posted write, repeated retries of a read, the flush, and the final acceptance of the same read.

// File: rtl/bridge_ord_pkg.sv
package bridge_ord_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_INT_ACK     = 4'h0,
    CMD_SPECIAL     = 4'h1,
    CMD_IO_RD       = 4'h2,
    CMD_IO_WR       = 4'h3,
    CMD_MEM_RD      = 4'h6,
    CMD_MEM_WR      = 4'h7,
    CMD_CFG_RD      = 4'hA,
    CMD_CFG_WR      = 4'hB,
    CMD_MEM_RD_MULT = 4'hC,
    CMD_MEM_RD_LINE = 4'hE,
    CMD_MEM_WR_INV  = 4'hF
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CLS_IGNORE   = 2'd0,
    CLS_POSTABLE = 2'd1,
    CLS_NONPOST  = 2'd2
  } cmd_class_e;

  typedef struct packed {
    logic retry;
    logic post;
    logic accept;
  } decision_t;

  // Class of a command code as seen by the crossing logic.
  function automatic cmd_class_e classify_cmd(input logic [CMD_W-1:0] code);
    cmd_class_e c;
    case (code)
      CMD_MEM_WR, CMD_MEM_WR_INV:                     c = CLS_POSTABLE;
      CMD_IO_RD, CMD_IO_WR, CMD_MEM_RD, CMD_CFG_RD,
      CMD_CFG_WR, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE:   c = CLS_NONPOST;
      default:                                        c = CLS_IGNORE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ord_cmd_class.sv
module ord_cmd_class
  import bridge_ord_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_class_e       cls
);

  always_comb cls = classify_cmd(cmd);

endmodule

// File: rtl/ord_cfg_ctl.sv
module ord_cfg_ctl #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int unsigned CTL_OFFSET = 'h40,
  parameter int          DIS_BIT    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic                strap_sw_ctl,
  output logic                posting_off
);

  localparam int               BE_W     = DATA_W / 8;
  localparam int               WORD_LSB = $clog2(BE_W);
  localparam int               DIS_LANE = DIS_BIT / 8;
  localparam logic [ADDR_W-1:0] OFS     = ADDR_W'(CTL_OFFSET);

  logic dis_q;
  logic hit;

  // Dword decode plus the byte lane that carries the flag.
  always_comb begin
    hit = cfg_wr
        && (cfg_addr[ADDR_W-1:WORD_LSB] == OFS[ADDR_W-1:WORD_LSB])
        && cfg_be[DIS_LANE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= 1'b0;
    end else if (hit) begin
      dis_q <= cfg_wdata[DIS_BIT];
    end
  end

  // The flag matters only while the strap hands control to software.
  always_comb posting_off = dis_q & strap_sw_ctl;

  logic unused_cfg_bits;
  always_comb unused_cfg_bits = ^{cfg_wdata, cfg_addr, cfg_be};

  // R6: the flag moves only on a configuration write
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(dis_q));

  // R6: a write to the control dword with the lane enabled loads the flag
  a_r6_load_on_hit: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_be[DIS_LANE]
     && cfg_addr[ADDR_W-1:WORD_LSB] == OFS[ADDR_W-1:WORD_LSB])
    |=> dis_q == $past(cfg_wdata[DIS_BIT]));

endmodule

// File: rtl/ord_side_decide.sv
module ord_side_decide
  import bridge_ord_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CMD_W-1:0] cmd,
  input  logic             far_empty,
  input  logic             posting_off,
  output decision_t        dec
);

  cmd_class_e cls;
  decision_t  dec_q;

  ord_cmd_class u_cls (
    .cmd (cmd),
    .cls (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= '0;
    end else begin
      dec_q <= '0;
      if (req) begin
        case (cls)
          CLS_POSTABLE: begin
            if (!posting_off)   dec_q.post   <= 1'b1;
            else if (far_empty) dec_q.accept <= 1'b1;
            else                dec_q.retry  <= 1'b1;
          end
          CLS_NONPOST: begin
            if (far_empty) dec_q.accept <= 1'b1;
            else           dec_q.retry  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign dec = dec_q;

  // R11: one outcome per request at most
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_q.retry, dec_q.post, dec_q.accept}));

  // R11: no strobe, no outcome
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !req |=> (dec_q == '0));

  // R4: ordering barrier against the opposite buffer
  a_r4_retry_when_pending: assert property (@(posedge clk) disable iff (rst)
    (req && cls == CLS_NONPOST && !far_empty) |=> dec_q.retry);

  // R3: barrier lifted once the opposite buffer drained
  a_r3_accept_when_clear: assert property (@(posedge clk) disable iff (rst)
    (req && cls == CLS_NONPOST && far_empty) |=> dec_q.accept);

  // R2: writes go straight into the buffer while posting is on
  a_r2_post_enabled: assert property (@(posedge clk) disable iff (rst)
    (req && cls == CLS_POSTABLE && !posting_off) |=> dec_q.post);

  // R5: unclaimed commands never see a response
  a_r5_unclaimed: assert property (@(posedge clk) disable iff (rst)
    (req && cls == CLS_IGNORE) |=> (dec_q == '0));

endmodule

// File: rtl/ord_flush_track.sv
module ord_flush_track (
  input  logic clk,
  input  logic rst,
  input  logic buf_empty,
  output logic flush_req
);

  logic flush_q;

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= ~buf_empty;
  end

  assign flush_req = flush_q;

  // R9: request raised while data waits
  a_r9_raise: assert property (@(posedge clk) disable iff (rst)
    !buf_empty |=> flush_req);

  // R9: request dropped once the buffer is empty
  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    buf_empty |=> !flush_req);

endmodule

// File: rtl/bridge_post_order.sv
module bridge_post_order
  import bridge_ord_pkg::*;
#(
  parameter int          CFG_ADDR_W = 8,
  parameter int          CFG_DATA_W = 32,
  parameter int unsigned CTL_OFFSET = 'h40,
  parameter int          DIS_BIT    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  in_req,
  input  logic [1:0][CMD_W-1:0]       in_cmd,
  input  logic [1:0]                  pbuf_empty,
  input  logic                        cfg_wr,
  input  logic [CFG_ADDR_W-1:0]       cfg_addr,
  input  logic [CFG_DATA_W-1:0]       cfg_wdata,
  input  logic [CFG_DATA_W/8-1:0]     cfg_be,
  input  logic                        strap_sw_ctl,
  output logic [1:0]                  dec_accept,
  output logic [1:0]                  dec_post,
  output logic [1:0]                  dec_retry,
  output logic [1:0]                  flush_req
);

  localparam int NSIDE = 2;

  logic posting_off;

  ord_cfg_ctl #(
    .ADDR_W     (CFG_ADDR_W),
    .DATA_W     (CFG_DATA_W),
    .CTL_OFFSET (CTL_OFFSET),
    .DIS_BIT    (DIS_BIT)
  ) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_be       (cfg_be),
    .strap_sw_ctl (strap_sw_ctl),
    .posting_off  (posting_off)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int FAR = NSIDE - 1 - s;
    decision_t dec;

    // A side is ordered only against writes that entered on the far side.
    ord_side_decide u_dec (
      .clk         (clk),
      .rst         (rst),
      .req         (in_req[s]),
      .cmd         (in_cmd[s]),
      .far_empty   (pbuf_empty[FAR]),
      .posting_off (posting_off),
      .dec         (dec)
    );

    ord_flush_track u_flush (
      .clk       (clk),
      .rst       (rst),
      .buf_empty (pbuf_empty[s]),
      .flush_req (flush_req[s])
    );

    assign dec_accept[s] = dec.accept;
    assign dec_post[s]   = dec.post;
    assign dec_retry[s]  = dec.retry;

    // R7: without the strap, software cannot stop posting
    a_r7_strap_gate: assert property (@(posedge clk) disable iff (rst)
      (!strap_sw_ctl && in_req[s] && classify_cmd(in_cmd[s]) == CLS_POSTABLE)
      |=> dec_post[s]);

    // R10: own buffer contents never cause a retry of a non-posted access
    a_r10_own_buffer: assert property (@(posedge clk) disable iff (rst)
      (in_req[s] && classify_cmd(in_cmd[s]) == CLS_NONPOST && pbuf_empty[FAR])
      |=> !dec_retry[s]);
  end

endmodule

// File: tb/tb_bridge_post_order.sv
module tb_bridge_post_order;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      in_req;
  logic [1:0][3:0] in_cmd;
  logic [1:0]      pbuf_empty;
  logic            cfg_wr;
  logic [7:0]      cfg_addr;
  logic [31:0]     cfg_wdata;
  logic [3:0]      cfg_be;
  logic            strap_sw_ctl;
  logic [1:0]      dec_accept, dec_post, dec_retry, flush_req;

  always #10 clk = ~clk;

  bridge_post_order dut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_cmd(in_cmd),
    .pbuf_empty(pbuf_empty), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .strap_sw_ctl(strap_sw_ctl),
    .dec_accept(dec_accept), .dec_post(dec_post), .dec_retry(dec_retry),
    .flush_req(flush_req)
  );

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  bit   dis_model = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  // {retry, post, accept} from the requirements
  function automatic logic [2:0] model(logic rq, logic [3:0] c, logic far_emp, logic off);
    logic pw, np;
    pw = (c == 4'h7) || (c == 4'hF);
    np = (c == 4'h2) || (c == 4'h3) || (c == 4'h6) || (c == 4'hA) ||
         (c == 4'hB) || (c == 4'hC) || (c == 4'hE);
    if (!rq) return 3'b000;
    if (pw && !off) return 3'b010;
    if (pw || np) return far_emp ? 3'b001 : 3'b100;
    return 3'b000;
  endfunction

  // Expected {flush, retry, post, accept} with two bits per field.
  function automatic logic [7:0] predict(logic [1:0] rq, logic [3:0] c0, logic [3:0] c1,
                                         logic [1:0] emp);
    logic [2:0] d0, d1;
    logic off;
    off = dis_model & strap_sw_ctl;
    d0 = model(rq[0], c0, emp[1], off);
    d1 = model(rq[1], c1, emp[0], off);
    return {~emp, d1[2], d0[2], d1[1], d0[1], d1[0], d0[0]};
  endfunction

  task automatic step(logic [1:0] rq, logic [3:0] c0, logic [3:0] c1,
                      logic [1:0] emp, string tag);
    @(negedge clk);
    in_req = rq; in_cmd[0] = c0; in_cmd[1] = c1; pbuf_empty = emp; cfg_wr = 1'b0;
    q_exp.push_back(predict(rq, c0, c1, emp));
    q_tag.push_back(tag);
  endtask

  task automatic set_strap(logic v);
    @(negedge clk);
    in_req = 2'b00; cfg_wr = 1'b0; strap_sw_ctl = v;
    q_exp.push_back(predict(2'b00, 4'h0, 4'h0, pbuf_empty));
    q_tag.push_back("R11 idle");
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    in_req = 2'b00; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    q_exp.push_back(predict(2'b00, 4'h0, 4'h0, pbuf_empty));
    q_tag.push_back("R6 cfg cycle");
    if (a[7:2] == 6'h10 && be[0]) dis_model = d[1];
  endtask

  // Monitor: compares one scoreboard item per cycle, mid-cycle after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_exp.size() > 0) begin
        logic [7:0] e, a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {flush_req, dec_retry, dec_post, dec_accept};
        n_tests++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b (flush,retry,post,accept)", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_req = 2'b00; in_cmd = '0; pbuf_empty = 2'b11;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_be = '0; strap_sw_ctl = 1'b1;
    in_req = 2'b11; in_cmd[0] = 4'h7; in_cmd[1] = 4'h6; pbuf_empty = 2'b00;
    repeat (3) @(negedge clk);
    n_tests++;
    if ({flush_req, dec_retry, dec_post, dec_accept} !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b expected %b",
               {flush_req, dec_retry, dec_post, dec_accept}, 8'h00);
    end
    in_req = 2'b00; pbuf_empty = 2'b11;
    rst = 1'b0;

    // R1: posting enabled straight after reset, strap high
    step(2'b01, 4'h7, 4'h0, 2'b11, "R1 posting on after reset");

    // R2 R3 R5: every code on side 0, far buffer empty
    for (int c = 0; c < 16; c++)
      step(2'b01, 4'(c), 4'h0, 2'b11, "R2 R3 R5 sweep side0");

    // R4 R5: every code on side 1 while side 0's buffer holds data
    for (int c = 0; c < 16; c++)
      step(2'b10, 4'h0, 4'(c), 2'b10, "R4 R5 sweep side1");

    // R10: own buffer non-empty, far empty
    step(2'b01, 4'h6, 4'h0, 2'b10, "R10 own buffer");
    step(2'b01, 4'hB, 4'h0, 2'b10, "R10 own buffer cfg");

    // R4: posted write, retries, flush, then acceptance
    step(2'b10, 4'h0, 4'hF, 2'b11, "R2 posted write");
    step(2'b00, 4'h0, 4'h0, 2'b01, "R9 buffer filled");
    for (int i = 0; i < 4; i++)
      step(2'b01, 4'h6, 4'h0, 2'b01, "R4 read retried");
    step(2'b00, 4'h0, 4'h0, 2'b11, "R9 buffer flushed");
    step(2'b01, 4'h6, 4'h0, 2'b11, "R4 read accepted after flush");

    // Both sides in the same cycle
    step(2'b11, 4'hE, 4'h7, 2'b11, "R3 R2 both sides");
    step(2'b11, 4'h2, 4'hC, 2'b00, "R4 both sides blocked");
    step(2'b00, 4'h0, 4'h0, 2'b11, "R11 idle");

    // R7: disable bit set but strap low
    set_strap(1'b0);
    cfg_write(8'h40, 32'h0000_0002, 4'h1);
    step(2'b01, 4'h7, 4'h0, 2'b11, "R7 strap low posts");
    step(2'b10, 4'h0, 4'hF, 2'b10, "R7 strap low posts mwi");

    // R8: strap high, posting off
    set_strap(1'b1);
    step(2'b01, 4'h7, 4'h0, 2'b11, "R8 write accepted non-posted");
    step(2'b01, 4'hF, 4'h0, 2'b01, "R8 write retried");

    // R6: writes that miss leave the flag set
    cfg_write(8'h40, 32'h0000_0000, 4'hE);
    step(2'b01, 4'h7, 4'h0, 2'b11, "R6 lane off keeps flag");
    cfg_write(8'h44, 32'h0000_0000, 4'hF);
    step(2'b01, 4'h7, 4'h0, 2'b11, "R6 other dword keeps flag");
    cfg_write(8'h43, 32'h0000_0000, 4'h1);
    step(2'b01, 4'h7, 4'h0, 2'b11, "R6 byte address in dword clears");

    for (int i = 0; i < 3; i++)
      step(2'b00, 4'h0, 4'h0, 2'b11, "R11 drain");
    wait (q_exp.size() == 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule